// File: doc/BRIEF.md
# Load Switch Supervisor Controller

This block sequences a power switch from digitised comparator results. There are two threshold comparisons each for an enable line and a sense line, plus an over-temperature flag whose hysteresis is applied before it reaches the block. From these inputs it drives three outputs: the switch enable, a power-good flag and an output-discharge enable. All timing comes from cycle counters with parameterised lengths.

Each of the enable and sense lines goes through a qualifier. A rising input becomes high only after a blanking interval spent above its upper threshold. A falling input becomes low only after a deglitch interval spent below its lower threshold. Between the two thresholds the qualified level holds.

A controller state machine sits behind the qualifiers. Its states are OFF, ARM, GOOD, RESTART and HOT:
- OFF: switch open.
- ARM: switch closed, power-good pending a fresh blanking interval.
- GOOD: switch closed, power-good high.
- RESTART: fixed-length off period after a sense fault.
- HOT: over-temperature off.

The transitions are:
- any state → OFF when qualified enable is low. This has the highest priority.
- any state → HOT when the over-temperature flag is set.
- OFF → ARM and HOT → ARM on the next cycle once nothing blocks the switch.
- ARM → GOOD after the sense input has been above its upper threshold for the blanking count.
- ARM → RESTART and GOOD → RESTART on a qualified falling edge of sense.
- RESTART → ARM when the restart count expires.

Top module: `lsw_supervisor`

## Requirements
- R1: While reset is held and on the first cycle after it, the switch enable is low, power-good is low and discharge is high.
- R2: The switch closes exactly BLANK_CYC+1 cycles after the enable input goes above its upper threshold and stays there. An excursion shorter than BLANK_CYC cycles never closes the switch.
- R3: The switch opens exactly DEGLITCH_CYC+1 cycles after the enable input goes below its lower threshold and stays there, and power-good drops with it. A dip shorter than DEGLITCH_CYC cycles changes nothing.
- R4: When an input is neither above its upper threshold nor below its lower one, its qualified level holds, so the outputs do not change.
- R5: In ARM, power-good rises BLANK_CYC cycles after the first cycle in ARM in which sense is above its upper threshold, provided sense stays there throughout.
- R6: A sense input below its lower threshold for DEGLITCH_CYC cycles is a fault. The switch opens and power-good drops DEGLITCH_CYC+1 cycles after the fall.
- R7: After a fault the switch stays open for exactly RESTART_CYC cycles and then closes again if enable is still qualified high, even with sense held low. Power-good stays low while sense stays low.
- R8: A sense recovery during the restart period does not shorten it.
- R9: After a restart, power-good rises only BLANK_CYC cycles after the switch closes again, even if sense was already high.
- R10: The over-temperature flag opens the switch on the next cycle. When the flag clears, the switch closes on the next cycle, and power-good follows BLANK_CYC cycles later with sense high.
- R11: The discharge output is high exactly when the switch enable is low.
- R12: A sense dip shorter than DEGLITCH_CYC cycles neither drops power-good nor starts a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_above_i | input | 1 | Enable line above its upper threshold |
| en_below_i | input | 1 | Enable line below its lower threshold |
| sns_above_i | input | 1 | Sense line above its upper threshold |
| sns_below_i | input | 1 | Sense line below its lower threshold |
| overtemp_i | input | 1 | Over-temperature flag, hysteresis applied outside |
| switch_on_o | output | 1 | Power switch enable |
| power_good_o | output | 1 | Power-good flag |
| discharge_o | output | 1 | Output discharge enable |

## Verification
Four rules are checked on every cycle:
- A qualified level changes only after its matching threshold input.
- Power-good follows a qualified-high enable and a sense input above threshold.
- An over-temperature flag always opens the switch on the following cycle.
- A restart in progress is never cut short while enable stays high.

The exact cycle counts of blanking, deglitch and restart, together with the glitch-rejection and quick-recovery cases, can only be shown by the bench's timed scenarios.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_GOOD,
        ST_RESTART,
        ST_HOT
    } lsw_state_e;

    localparam int CH_EN  = 0;
    localparam int CH_SNS = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/lsw_qualifier.sv
module lsw_qualifier #(
    parameter int RISE_CYC = 8,
    parameter int FALL_CYC = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic above_i,
    input  logic below_i,
    output logic level_o
);

    localparam int MAXC = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

    logic          lvl_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (!lvl_q) begin
            // rising qualification: uninterrupted run above the upper threshold
            if (above_i) begin
                if (cnt_q == RISE_LAST) begin
                    lvl_q <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end else begin
            // falling qualification: uninterrupted run below the lower threshold
            if (below_i) begin
                if (cnt_q == FALL_LAST) begin
                    lvl_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign level_o = lvl_q;

    // R2
    rise_after_above_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lvl_q) |-> $past(above_i));

    // R3
    fall_after_below_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(lvl_q) |-> $past(below_i));

endmodule

// File: rtl/lsw_ctrl_fsm.sv
module lsw_ctrl_fsm
    import lsw_pkg::*;
#(
    parameter int BLANK_CYC   = 8,
    parameter int RESTART_CYC = 20
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_q_i,
    input  logic sns_q_i,
    input  logic sns_above_i,
    input  logic overtemp_i,
    output logic sw_on_o,
    output logic pg_o,
    output logic dis_o
);

    localparam int MAXC = (BLANK_CYC > RESTART_CYC) ? BLANK_CYC : RESTART_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] RST_LAST   = CW'(RESTART_CYC - 1);

    lsw_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sns_dly_q;
    logic          sns_fall;

    assign sns_fall = sns_dly_q & ~sns_q_i;

    // next-state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en_q_i) begin
            st_d = ST_OFF;
        end else if (overtemp_i) begin
            st_d = ST_HOT;
        end else begin
            unique case (st_q)
                ST_OFF:     st_d = ST_ARM;
                ST_HOT:     st_d = ST_ARM;
                ST_ARM: begin
                    if (sns_fall)
                        st_d = ST_RESTART;
                    else if (sns_above_i && cnt_q == BLANK_LAST)
                        st_d = ST_GOOD;
                end
                ST_GOOD: begin
                    if (sns_fall)
                        st_d = ST_RESTART;
                end
                ST_RESTART: begin
                    if (cnt_q == RST_LAST)
                        st_d = ST_ARM;
                end
                default:    st_d = ST_OFF;
            endcase
        end

        if (st_d != st_q) begin
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_ARM:     cnt_d = sns_above_i ? cnt_q + 1'b1 : '0;
                ST_RESTART: cnt_d = cnt_q + 1'b1;
                default:    cnt_d = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q      <= ST_OFF;
            cnt_q     <= '0;
            sns_dly_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            sns_dly_q <= sns_q_i;
        end
    end

    // outputs
    always_comb begin
        sw_on_o = 1'b0;
        pg_o    = 1'b0;
        unique case (st_q)
            ST_ARM:  sw_on_o = 1'b1;
            ST_GOOD: begin
                sw_on_o = 1'b1;
                pg_o    = 1'b1;
            end
            default: ;
        endcase
        dis_o = ~sw_on_o;
    end

    // R3
    pg_needs_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pg_o |-> $past(en_q_i));

    // R5
    pg_rise_needs_sense_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pg_o) |-> $past(sns_above_i));

    // R10
    hot_opens_switch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        overtemp_i |=> !sw_on_o);

    // R8
    restart_full_length_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RESTART && cnt_q != RST_LAST && en_q_i && !overtemp_i)
            |=> (st_q == ST_RESTART && !sw_on_o));

endmodule

// File: rtl/lsw_supervisor.sv
module lsw_supervisor
    import lsw_pkg::*;
#(
    parameter int BLANK_CYC    = 5000,
    parameter int DEGLITCH_CYC = 250,
    parameter int RESTART_CYC  = 100000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_above_i,
    input  logic en_below_i,
    input  logic sns_above_i,
    input  logic sns_below_i,
    input  logic overtemp_i,
    output logic switch_on_o,
    output logic power_good_o,
    output logic discharge_o
);

    logic [N_CH-1:0] above_vec, below_vec, level_vec;

    assign above_vec[CH_EN]  = en_above_i;
    assign below_vec[CH_EN]  = en_below_i;
    assign above_vec[CH_SNS] = sns_above_i;
    assign below_vec[CH_SNS] = sns_below_i;

    for (genvar g = 0; g < N_CH; g++) begin : g_qual
        lsw_qualifier #(
            .RISE_CYC (BLANK_CYC),
            .FALL_CYC (DEGLITCH_CYC)
        ) u_qual (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .above_i (above_vec[g]),
            .below_i (below_vec[g]),
            .level_o (level_vec[g])
        );
    end

    lsw_ctrl_fsm #(
        .BLANK_CYC   (BLANK_CYC),
        .RESTART_CYC (RESTART_CYC)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_q_i      (level_vec[CH_EN]),
        .sns_q_i     (level_vec[CH_SNS]),
        .sns_above_i (sns_above_i),
        .overtemp_i  (overtemp_i),
        .sw_on_o     (switch_on_o),
        .pg_o        (power_good_o),
        .dis_o       (discharge_o)
    );

    // R11
    discharge_vs_switch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        discharge_o != switch_on_o);

endmodule

// File: tb/lsw_supervisor_tb.sv
module lsw_supervisor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int B = 8;
    localparam int D = 3;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst;
    logic en_above, en_below, sns_above, sns_below, overtemp;
    logic switch_on, power_good, discharge;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        logic  sw;
        logic  pg;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lsw_supervisor #(
        .BLANK_CYC    (B),
        .DEGLITCH_CYC (D),
        .RESTART_CYC  (R)
    ) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .en_above_i   (en_above),
        .en_below_i   (en_below),
        .sns_above_i  (sns_above),
        .sns_below_i  (sns_below),
        .overtemp_i   (overtemp),
        .switch_on_o  (switch_on),
        .power_good_o (power_good),
        .discharge_o  (discharge)
    );

    // monitor: pop due expectations and compare at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (switch_on !== e.sw || power_good !== e.pg) begin
                n_fail++;
                $display("FAIL %s cyc %0d: sw/pg actual %b%b expected %b%b",
                         e.tag, cyc, switch_on, power_good, e.sw, e.pg);
            end
            n_checks++;
            if (discharge !== ~e.sw) begin
                n_fail++;
                $display("FAIL R11 cyc %0d: discharge actual %b expected %b",
                         cyc, discharge, ~e.sw);
            end
        end
    end

    task automatic expect_at(input int n, input logic sw, input logic pg, input string tag);
        exp_t e;
        e.due = cyc + n;
        e.sw  = sw;
        e.pg  = pg;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_en(input logic a, input logic b);
        en_above = a;
        en_below = b;
    endtask

    task automatic set_sns(input logic a, input logic b);
        sns_above = a;
        sns_below = b;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        set_en(1'b0, 1'b1);
        set_sns(1'b0, 1'b1);
        overtemp = 1'b0;
        run(3);
        rst = 1'b0;
        // R1 reset state
        expect_at(1, 1'b0, 1'b0, "R1 reset state");
        run(1);

        // R2 short enable excursion ignored
        set_en(1'b1, 1'b0);
        set_sns(1'b1, 1'b0);
        expect_at(B-1, 1'b0, 1'b0, "R2 short pulse");
        run(B-1);
        set_en(1'b0, 1'b0);
        expect_at(4, 1'b0, 1'b0, "R2 short pulse ignored");
        run(4);

        // R2 / R5 normal power-up
        set_en(1'b1, 1'b0);
        expect_at(B,     1'b0, 1'b0, "R2 before blank end");
        expect_at(B+1,   1'b1, 1'b0, "R2 switch closes");
        expect_at(2*B,   1'b1, 1'b0, "R5 pg pending");
        expect_at(2*B+1, 1'b1, 1'b1, "R5 pg rises");
        run(2*B+1);

        // R12 short sense dip
        set_sns(1'b0, 1'b1);
        expect_at(D-1, 1'b1, 1'b1, "R12 during dip");
        run(D-1);
        set_sns(1'b1, 1'b0);
        expect_at(3, 1'b1, 1'b1, "R12 dip ignored");
        run(3);

        // R4 inputs between thresholds
        set_en(1'b0, 1'b0);
        set_sns(1'b0, 1'b0);
        expect_at(10, 1'b1, 1'b1, "R4 hold level");
        run(10);
        set_en(1'b1, 1'b0);
        set_sns(1'b1, 1'b0);

        // R6 / R7 fault with sense held low
        set_sns(1'b0, 1'b1);
        expect_at(D,      1'b1, 1'b1, "R6 before deglitch end");
        expect_at(D+1,    1'b0, 1'b0, "R6 fault opens switch");
        expect_at(D+R,    1'b0, 1'b0, "R7 still restarting");
        expect_at(D+R+1,  1'b1, 1'b0, "R7 reclose with sense low");
        expect_at(D+R+11, 1'b1, 1'b0, "R7 pg stays low");
        run(D+R+11);
        set_sns(1'b1, 1'b0);
        expect_at(B-1, 1'b1, 1'b0, "R5 pg pending after sense up");
        expect_at(B,   1'b1, 1'b1, "R5 pg after blank");
        run(B);

        // R8 / R9 quick recovery during restart
        set_sns(1'b0, 1'b1);
        expect_at(D+5, 1'b0, 1'b0, "R8 in restart");
        run(D+5);
        set_sns(1'b1, 1'b0);
        expect_at(R-5,     1'b0, 1'b0, "R8 recovery ignored");
        expect_at(R-4,     1'b1, 1'b0, "R8 full restart length");
        expect_at(R-4+B-1, 1'b1, 1'b0, "R9 fresh blank pending");
        expect_at(R-4+B,   1'b1, 1'b1, "R9 pg after fresh blank");
        run(R-4+B);

        // R10 over-temperature
        overtemp = 1'b1;
        expect_at(1, 1'b0, 1'b0, "R10 hot opens");
        expect_at(5, 1'b0, 1'b0, "R10 hot holds");
        run(5);
        overtemp = 1'b0;
        expect_at(1,   1'b1, 1'b0, "R10 reclose");
        expect_at(B,   1'b1, 1'b0, "R10 pg pending");
        expect_at(B+1, 1'b1, 1'b1, "R10 pg back");
        run(B+1);

        // R3 enable dip and fall
        set_en(1'b0, 1'b1);
        expect_at(D-1, 1'b1, 1'b1, "R3 during dip");
        run(D-1);
        set_en(1'b1, 1'b0);
        expect_at(3, 1'b1, 1'b1, "R3 dip ignored");
        run(3);
        set_en(1'b0, 1'b1);
        expect_at(D,   1'b1, 1'b1, "R3 before deglitch end");
        expect_at(D+1, 1'b0, 1'b0, "R3 enable off");
        expect_at(D+6, 1'b0, 1'b0, "R3 stays off");
        run(D+7);

        finish_run();
    end

endmodule